// File: doc/BRIEF.md
# Pipelined Bus Cycle Sequencer

This block sequences the clock-by-clock phases of every transfer on a multiplexed address/data bus. Each transfer passes through two hidden preparation phases (TS, then T0) in which the address is computed, and then through the visible phases: T1 carries the address, T2 turns the bus around, T3 moves the data (and repeats while the target is not ready), and a final T4 needs no stored state. When requests follow each other, the next transfer's TS and T0 run alongside the current transfer's T3 and T4. A new transfer can therefore begin every four clocks, while a lone transfer costs six.

The sequencer takes a level-sensitive request with a flag that tells a prefetch from an instruction-driven access. It also takes a strobe for a pointer-correction micro-operation, a strobe that stops prefetching, a halt level, a hold level (another master wants the bus) and the target's ready input. It drives a one-hot vector of the four stored phases and a registered bus-active flag. Other logic in the interface unit uses these to steer the address adder, the pins and the data latches.

Top module: `bus_tstate_seq`

## Requirements
- R1: A synchronous active-high reset clears all four phase flip-flops and the bus-active flag. The clock after reset is released shows the idle state.
- R2: The phase vector `t_state_o` encodes T0 on bit 0, T1 on bit 1, T2 on bit 2 and T3 on bit 3. A request seen while idle is its TS clock, and the next clocks show T0, T1, T2 and T3, each for one clock, followed by idle. T2 is always followed by T3.
- R3: In a T3 with ready high, a pending request and hold low, the next transfer's TS is taken, so T0 directly follows T3.
- R4: While ready is low in a T3 reached through T2, the machine stays in T3 for another clock.
- R5: Hold high blocks a request from starting a transfer, both from idle and from T3.
- R6: A correction strobe seen while idle starts a short transfer even while hold is high. That transfer shows T0 for one clock and then returns to idle without a T1.
- R7: If an instruction request (prefetch flag low) arrives while a prefetch is in T0, the prefetch is dropped before T1. The next clock is T3, and the clock after that is T0 of the instruction access, regardless of ready.
- R8: A correction or suspend strobe during a prefetch's T0 ends the transfer after T0, so the next clock is idle. A suspend strobe during the T0 of an instruction access has no effect, so T1 follows.
- R9: With halt high and the bus idle, exactly one T1 is shown, with no T2 after it. No further T1 follows while halt stays high.
- R10: Hold high rearms the halt indication, so a fresh single T1 is shown on the first idle clock after hold falls while halt is still high.
- R11: A halt raised during an active transfer waits until that transfer has left T3, and the halt T1 is then shown on the following clock.
- R12: At most one phase bit is set at any time, and `bus_active_o` is high exactly when one is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Bus transfer request, level |
| req_pf_i | input | 1 | 1: the pending request is a prefetch; 0: instruction-driven |
| corr_i | input | 1 | Pointer-correction micro-operation strobe |
| susp_i | input | 1 | Stop-prefetching micro-operation strobe |
| halt_i | input | 1 | Processor halted |
| hold_i | input | 1 | Another master requests the bus |
| ready_i | input | 1 | Target ready; low in T3 inserts a wait state |
| t_state_o | output | 4 | One-hot stored phase: bit0 T0, bit1 T1, bit2 T2, bit3 T3 |
| bus_active_o | output | 1 | Registered flag, high during T0 through T3 |

## Verification
Several rules are checked on every clock by the assertions. The phase vector must never hold more than one set bit, and the bus-active flag must agree with it. T2 must always advance to T3, and a wait must hold T3. A halt T1 must never be followed by T2, a committed preempt must land in T3, and hold must stop a T3 from chaining into T0. Other behaviour can only be shown by the bench's scenarios. These cover the six-clock lone transfer and the four-clock chained cadence, the short correction transfer under hold, and the preempt path that ignores ready. They also cover the susp/corr aborts, which apply only to prefetches, and the halt indication: issued once, rearmed by hold, and held back by a transfer in flight.

// File: rtl/bus_tstate_pkg.sv
package bus_tstate_pkg;
  localparam int NUM_PH = 4;
  localparam int PH_T0  = 0;
  localparam int PH_T1  = 1;
  localparam int PH_T2  = 2;
  localparam int PH_T3  = 3;
  typedef logic [NUM_PH-1:0] ph_vec_t;
endpackage

// File: rtl/bus_tstate_launch.sv
module bus_tstate_launch (
  input  logic clk,
  input  logic rst,
  input  logic t0,
  input  logic t3,
  input  logic bact,
  input  logic req,
  input  logic req_pf,
  input  logic corr,
  input  logic susp,
  input  logic hold,
  input  logic ready,
  output logic ts,
  output logic t0_adv,
  output logic t0_pre,
  output logic pre_q
);
  logic cur_pf_q, cur_corr_q;
  logic go_idle, go_tail, drop_t0;

  // a request may launch only when no other master owns the bus; a correction needs no pins
  assign go_idle = ~bact & (corr | (req & ~hold));
  assign go_tail = t3 & ((ready & req & ~hold) | pre_q);
  assign ts      = go_idle | go_tail;

  assign t0_pre  = t0 & cur_pf_q & ~cur_corr_q & req & ~req_pf & ~corr & ~susp;
  assign drop_t0 = t0 & (cur_corr_q | (cur_pf_q & (corr | susp)));
  assign t0_adv  = t0 & ~drop_t0 & ~t0_pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_pf_q   <= 1'b0;
      cur_corr_q <= 1'b0;
      pre_q      <= 1'b0;
    end else begin
      pre_q <= t0_pre;
      if (ts) begin
        cur_corr_q <= go_idle & corr;
        cur_pf_q   <= req_pf & ~(go_idle & corr);
      end
    end
  end

  assert_hold_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (t3 & ready & hold & ~pre_q) |=> !t0);
endmodule

// File: rtl/bus_tstate_halt.sv
module bus_tstate_halt (
  input  logic clk,
  input  logic rst,
  input  logic halt,
  input  logic hold,
  input  logic bact,
  input  logic ts,
  output logic halt_t1,
  output logic halt_cyc_q
);
  logic shown_q;

  assign halt_t1 = halt & ~shown_q & ~hold & ~bact & ~ts;

  always_ff @(posedge clk) begin
    if (rst) begin
      shown_q    <= 1'b0;
      halt_cyc_q <= 1'b0;
    end else begin
      halt_cyc_q <= halt_t1;
      if (hold | ~halt) shown_q <= 1'b0;
      else if (halt_t1) shown_q <= 1'b1;
    end
  end

  assert_single_halt_R9: assert property (@(posedge clk) disable iff (rst)
    halt_cyc_q |-> !halt_t1);
endmodule

// File: rtl/bus_tstate_ring.sv
module bus_tstate_ring
  import bus_tstate_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    ts,
  input  logic    t0_adv,
  input  logic    t0_pre,
  input  logic    pre_q,
  input  logic    halt_t1,
  input  logic    halt_cyc,
  input  logic    ready,
  output ph_vec_t ph_q,
  output ph_vec_t ph_d
);
  always_comb begin
    ph_d        = '0;
    ph_d[PH_T0] = ts;
    ph_d[PH_T1] = t0_adv | halt_t1;
    ph_d[PH_T2] = ph_q[PH_T1] & ~halt_cyc;
    ph_d[PH_T3] = ph_q[PH_T2] | (ph_q[PH_T3] & ~ready & ~pre_q) | t0_pre;
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= ph_d;
  end

  assert_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ph_q));
  assert_t2_then_t3_R2: assert property (@(posedge clk) disable iff (rst)
    ph_q[PH_T2] |=> ph_q[PH_T3]);
  assert_wait_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (ph_q[PH_T3] & ~ready & ~pre_q) |=> ph_q[PH_T3]);
  assert_halt_no_t2_R9: assert property (@(posedge clk) disable iff (rst)
    (ph_q[PH_T1] & halt_cyc) |=> !ph_q[PH_T2]);
  assert_preempt_t3_R7: assert property (@(posedge clk) disable iff (rst)
    t0_pre |=> ph_q[PH_T3]);
endmodule

// File: rtl/bus_tstate_seq.sv
module bus_tstate_seq
  import bus_tstate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              req_pf_i,
  input  logic              corr_i,
  input  logic              susp_i,
  input  logic              halt_i,
  input  logic              hold_i,
  input  logic              ready_i,
  output logic [NUM_PH-1:0] t_state_o,
  output logic              bus_active_o
);
  ph_vec_t ph_q, ph_d;
  logic ts, t0_adv, t0_pre, pre_q, halt_t1, halt_cyc;
  logic bact_q;

  bus_tstate_launch u_launch (
    .clk(clk), .rst(rst), .t0(ph_q[PH_T0]), .t3(ph_q[PH_T3]), .bact(bact_q),
    .req(req_i), .req_pf(req_pf_i), .corr(corr_i), .susp(susp_i),
    .hold(hold_i), .ready(ready_i), .ts(ts), .t0_adv(t0_adv),
    .t0_pre(t0_pre), .pre_q(pre_q)
  );

  bus_tstate_halt u_halt (
    .clk(clk), .rst(rst), .halt(halt_i), .hold(hold_i), .bact(bact_q),
    .ts(ts), .halt_t1(halt_t1), .halt_cyc_q(halt_cyc)
  );

  bus_tstate_ring u_ring (
    .clk(clk), .rst(rst), .ts(ts), .t0_adv(t0_adv), .t0_pre(t0_pre),
    .pre_q(pre_q), .halt_t1(halt_t1), .halt_cyc(halt_cyc), .ready(ready_i),
    .ph_q(ph_q), .ph_d(ph_d)
  );

  // bus-active is registered from the next-phase terms, one clock ahead of use
  always_ff @(posedge clk) begin
    if (rst) bact_q <= 1'b0;
    else     bact_q <= |ph_d;
  end

  assign t_state_o    = ph_q;
  assign bus_active_o = bact_q;

  assert_active_match_R12: assert property (@(posedge clk) disable iff (rst)
    bus_active_o == (|t_state_o));
endmodule

// File: tb/bus_tstate_seq_bench.sv
module bus_tstate_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 0, pf = 0, corr = 0, susp = 0, halt = 0, hold = 0, ready = 1;
  logic [3:0] t_state;
  logic       bact;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bus_tstate_seq u_bus_tstate_seq (
    .clk(clk), .rst(rst), .req_i(req), .req_pf_i(pf), .corr_i(corr),
    .susp_i(susp), .halt_i(halt), .hold_i(hold), .ready_i(ready),
    .t_state_o(t_state), .bus_active_o(bact)
  );

  // {requirement, req pf corr susp halt hold ready, expected phase after the edge}
  localparam logic [14:0] VEC [0:56] = '{
    // R2 lone transfer
    {4'd2, 7'b1000001, 4'b0001}, {4'd2, 7'b0000001, 4'b0010},
    {4'd2, 7'b0000001, 4'b0100}, {4'd2, 7'b0000001, 4'b1000},
    {4'd2, 7'b0000001, 4'b0000},
    // R3 chaining, R4 wait state
    {4'd3, 7'b1000001, 4'b0001}, {4'd2, 7'b0000001, 4'b0010},
    {4'd2, 7'b0000001, 4'b0100}, {4'd4, 7'b0000000, 4'b1000},
    {4'd4, 7'b0000000, 4'b1000}, {4'd3, 7'b1000001, 4'b0001},
    {4'd2, 7'b0000001, 4'b0010}, {4'd2, 7'b0000001, 4'b0100},
    {4'd2, 7'b0000001, 4'b1000}, {4'd2, 7'b0000001, 4'b0000},
    // R5 hold blocks, R6 correction under hold
    {4'd2, 7'b1000001, 4'b0001}, {4'd2, 7'b0000001, 4'b0010},
    {4'd2, 7'b0000001, 4'b0100}, {4'd2, 7'b0000001, 4'b1000},
    {4'd5, 7'b1000011, 4'b0000}, {4'd5, 7'b1000011, 4'b0000},
    {4'd6, 7'b0010011, 4'b0001}, {4'd6, 7'b0000011, 4'b0000},
    {4'd6, 7'b0000001, 4'b0000},
    // R7 preempt of a prefetch
    {4'd7, 7'b1100001, 4'b0001}, {4'd7, 7'b1000001, 4'b1000},
    {4'd7, 7'b1000000, 4'b0001}, {4'd7, 7'b0000001, 4'b0010},
    {4'd7, 7'b0000001, 4'b0100}, {4'd7, 7'b0000001, 4'b1000},
    {4'd7, 7'b0000001, 4'b0000},
    // R8 suspend: aborts prefetch, ignored on instruction access
    {4'd8, 7'b1100001, 4'b0001}, {4'd8, 7'b0001001, 4'b0000},
    {4'd8, 7'b0000001, 4'b0000}, {4'd8, 7'b1000001, 4'b0001},
    {4'd8, 7'b0001001, 4'b0010}, {4'd8, 7'b0000001, 4'b0100},
    {4'd8, 7'b0000001, 4'b1000}, {4'd8, 7'b0000001, 4'b0000},
    // R9 single halt T1, R10 rearm through hold
    {4'd9, 7'b0000101, 4'b0010}, {4'd9, 7'b0000101, 4'b0000},
    {4'd9, 7'b0000101, 4'b0000}, {4'd10, 7'b0000111, 4'b0000},
    {4'd10, 7'b0000101, 4'b0010}, {4'd10, 7'b0000101, 4'b0000},
    {4'd10, 7'b0000001, 4'b0000},
    // R11 halt waits for a transfer in flight
    {4'd11, 7'b1000001, 4'b0001}, {4'd11, 7'b0000101, 4'b0010},
    {4'd11, 7'b0000101, 4'b0100}, {4'd11, 7'b0000101, 4'b1000},
    {4'd11, 7'b0000101, 4'b0000}, {4'd11, 7'b0000101, 4'b0010},
    {4'd11, 7'b0000101, 4'b0000}, {4'd11, 7'b0000001, 4'b0000},
    // R8 correction aborts prefetch
    {4'd8, 7'b1100001, 4'b0001}, {4'd8, 7'b0010001, 4'b0000},
    {4'd8, 7'b0000001, 4'b0000}
  };

  task automatic check(input int rq, input logic [3:0] exp_ph);
    checks++;
    if (t_state !== exp_ph) begin
      errors++;
      $display("FAIL R%0d phase: actual %b expected %b", rq, t_state, exp_ph);
    end
    // R12 bus-active agrees with the phase; at most one phase bit
    checks++;
    if (bact !== (|exp_ph) || $countones(t_state) > 1) begin
      errors++;
      $display("FAIL R12 active/onehot: actual %b/%b expected %b", bact, t_state, |exp_ph);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 4'b0000);   // R1 state during reset
    rst = 1'b0;
    @(negedge clk);
    check(1, 4'b0000);   // R1 idle after release
    for (int i = 0; i < 57; i++) begin
      {req, pf, corr, susp, halt, hold, ready} = VEC[i][10:4];
      @(posedge clk);
      @(negedge clk);
      check(int'(VEC[i][14:11]), VEC[i][3:0]);
    end
    // R1 reset in the middle of a transfer
    {req, pf, corr, susp, halt, hold, ready} = 7'b1000001;
    @(posedge clk); @(negedge clk);
    req = 0;
    @(posedge clk); @(negedge clk);
    check(2, 4'b0010);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(1, 4'b0000);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check(1, 4'b0000);
    finish_run();
  end
endmodule